// File: doc/BRIEF.md
# Multicore Spin-Table Release Controller

This block keeps a small table in memory space with one 32-byte boot record for each secondary core. Each record holds an entry address, an argument value, a processor-ID word and two reserved fields. After reset every core is parked, because bit 0 of its entry address is set. Boot software writes the record fields through a plain bus slave port that uses big-endian byte order. To start a core, software clears bit 0 of that core's entry address.

When a write leaves that bit at zero, the block raises a one-cycle strobe for that core. It also drives a shared launch payload. The payload carries the entry address split into a 64 MiB-aligned window base and an offset inside the window, the record's argument value, and the window size. In the same cycle the record's ID word is replaced with the core's real ID, so software can see which cores have started. Record 0 belongs to the boot core and cannot be written. Records of absent cores cannot be written either.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, record k holds an entry address of 1, an argument value of k, an ID word of k, and zero in both reserved fields. No release strobe and no read error are active.
- R2: Bus address bits [ADDR_W-1:5] select the record and bits [4:0] select the byte inside it. Record bytes 0-7 are the 64-bit entry address, bytes 8-15 the argument, bytes 16-19 reserved, bytes 20-23 the ID word and bytes 24-31 reserved. Every field is big-endian, so its lowest-addressed byte is its most significant byte.
- R3: A write with `bus_size` of 1, 2 or 4 stores the low `bus_size` bytes of `bus_wdata` big-endian. Address bits below the access size are ignored, which aligns the access. A write of any other size changes nothing.
- R4: A read of size 1, 2 or 4 returns the addressed bytes big-endian and right-aligned in `bus_rdata` one cycle later. A read of any other size raises `bus_rerr` for one cycle, with `bus_rdata` set to 0.
- R5: A write to record 0, to a record whose `core_present` bit is 0, or to a record at or above NUM_CORES is dropped. Neither the record nor any release output changes.
- R6: After an accepted write to record k, if the updated entry-address bit 0 is 0, `rel_pulse[k]` is high for exactly the one cycle after the write. At most one strobe bit is high at a time.
- R7: Once core k has been released, it gets no further strobe until an accepted write sets entry bit 0 back to 1. A later write that leaves bit 0 at zero then releases it again.
- R8: While a strobe is high, `rel_offset` equals the entry address AND (2^26-1) and `rel_base` equals the entry address with bits 25:0 cleared. `rel_arg` equals the argument field and `rel_win` equals 2^26. All four are 0 while no strobe is high.
- R9: On the release of core k, the ID word of record k is overwritten with `core_id[32k+31:32k]`.
- R10: Release detection uses the record contents after the write. A single 4-byte write to byte offset 4 can therefore release a core, and the payload includes the high word that the write left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the table |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, valid the cycle after a read |
| bus_rerr | output | 1 | Read size error, one-cycle flag |
| core_present | input | NUM_CORES | Bit k is set when core k exists |
| core_id | input | 32*NUM_CORES | Real ID of core k in bits 32k+31:32k |
| rel_pulse | output | NUM_CORES | One-cycle release strobe per core |
| rel_base | output | 64 | 64 MiB-aligned window base of the released core |
| rel_offset | output | 64 | Start offset inside the window |
| rel_arg | output | 64 | First launch argument (record argument field) |
| rel_win | output | 64 | Second launch argument (window size) |

## Verification
In a single cycle the block merges the byte lanes of a write into a record, tests the merged entry bit 0 to decide on a release, and loads the core's ID word into that same record. The bench makes all three happen in one access. It writes the low word of the entry address with bit 0 clear, after the high word has been set by an earlier write. It then checks that the strobe and payload in the following cycle reflect the merged 64-bit value, and that a later read of the ID word returns the core's real ID rather than the reset value. A repeat write with bit 0 still clear must produce no strobe. A byte write that sets bit 0 again and a second one that clears it must together produce exactly one new strobe.

// File: rtl/spin_pkg.sv
package spin_pkg;
    localparam int REC_BYTES = 32;
    localparam int OFF_W     = $clog2(REC_BYTES);
    localparam int REC_BITS  = REC_BYTES * 8;
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = BUS_BYTES * 8;
    localparam int WIN_LOG2  = 26;
    localparam logic [63:0] WIN_SIZE = 64'd1 << WIN_LOG2;
    localparam logic [63:0] WIN_MASK = WIN_SIZE - 64'd1;

    // record fields, byte 0 at the MSB of the flat record vector
    localparam int EA_HI  = REC_BITS - 1;       // entry address [255:192]
    localparam int EA_LSB = REC_BITS - 64;      // bit 0 of entry address
    localparam int ARG_HI = REC_BITS - 65;      // argument [191:128]
    localparam int ID_HI  = REC_BITS - 161;     // ID word [95:64]

    typedef struct packed {
        logic [REC_BITS-1:0] rec;
        logic                armed;
        logic                fire;
    } rec_state_t;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             rerr;
    } rd_state_t;
endpackage

// File: rtl/spin_lane_dec.sv
module spin_lane_dec
    import spin_pkg::*;
(
    input  logic [OFF_W-1:0]    off,
    input  logic [2:0]          size,
    input  logic [BUS_W-1:0]    wdata,
    output logic                size_ok,
    output logic [OFF_W-1:0]    base_off,
    output logic [REC_BITS-1:0] wmask,
    output logic [REC_BITS-1:0] wbits
);
    int rel;
    int nb;

    always_comb begin
        size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        nb       = int'(size);
        case (size)
            3'd2:    base_off = {off[OFF_W-1:1], 1'b0};
            3'd4:    base_off = {off[OFF_W-1:2], 2'b00};
            default: base_off = off;
        endcase
        wmask = '0;
        wbits = '0;
        for (int j = 0; j < REC_BYTES; j++) begin
            rel = j - int'(base_off);
            if (size_ok && rel >= 0 && rel < nb) begin
                wmask[8*(REC_BYTES-1-j) +: 8] = 8'hFF;
                wbits[8*(REC_BYTES-1-j) +: 8] = wdata[8*(nb-1-rel) +: 8];
            end
        end
    end
endmodule

// File: rtl/spin_record.sv
module spin_record
    import spin_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REC_BITS-1:0] wmask,
    input  logic [REC_BITS-1:0] wbits,
    input  logic [31:0]         core_id,
    output logic [REC_BITS-1:0] rec_q,
    output logic                fire_q
);
    localparam logic [REC_BITS-1:0] REC_RST =
        {64'd1, 64'(IDX), 32'd0, 32'(IDX), 64'd0};

    rec_state_t s_d, s_q;
    logic [REC_BITS-1:0] merged;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        merged   = (s_q.rec & ~wmask) | (wbits & wmask);
        if (wr_en) begin
            s_d.rec = merged;
            if (!merged[EA_LSB]) begin
                if (s_q.armed) begin
                    s_d.fire  = 1'b1;
                    s_d.armed = 1'b0;
                    s_d.rec[ID_HI -: 32] = core_id;
                end
            end else begin
                s_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rec   <= REC_RST;
            s_q.armed <= 1'b1;
            s_q.fire  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rec_q  = s_q.rec;
    assign fire_q = s_q.fire;

    // R6: strobe lasts one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);
    // R6: strobe only with entry bit 0 clear
    p_fire_bit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> !rec_q[EA_LSB]);
    // R5: record holds without an accepted write
    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rec_q));
    // R9: released core's ID word is loaded
    p_id_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> rec_q[ID_HI -: 32] == $past(core_id));
endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
    import spin_pkg::*;
#(
    parameter int NUM_CORES = 32,
    localparam int ADDR_W   = $clog2(NUM_CORES * REC_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [2:0]              bus_size,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [BUS_W-1:0]        bus_rdata,
    output logic                    bus_rerr,
    input  logic [NUM_CORES-1:0]    core_present,
    input  logic [32*NUM_CORES-1:0] core_id,
    output logic [NUM_CORES-1:0]    rel_pulse,
    output logic [63:0]             rel_base,
    output logic [63:0]             rel_offset,
    output logic [63:0]             rel_arg,
    output logic [63:0]             rel_win
);
    localparam int IDX_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]    idx;
    logic [OFF_W-1:0]    off;
    logic                size_ok;
    logic [OFF_W-1:0]    base_off;
    logic [REC_BITS-1:0] wmask, wbits;
    logic                in_range;
    logic                wr_ok;
    logic [NUM_CORES-1:0] wr_en;
    logic [NUM_CORES-1:0] fire;
    logic [REC_BITS-1:0] recs [NUM_CORES];
    logic [REC_BITS-1:0] sel;
    logic [63:0]         ea;
    rd_state_t           rd_d, rd_q;

    assign idx      = bus_addr[ADDR_W-1:OFF_W];
    assign off      = bus_addr[OFF_W-1:0];
    assign in_range = int'(idx) < NUM_CORES;

    spin_lane_dec u_lanes (
        .off      (off),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .size_ok  (size_ok),
        .base_off (base_off),
        .wmask    (wmask),
        .wbits    (wbits)
    );

    always_comb begin
        wr_ok = bus_req && bus_wr && size_ok && in_range && (idx != '0)
                && core_present[idx];
    end

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_rec
        assign wr_en[k] = wr_ok && (int'(idx) == k);
        spin_record #(.IDX(k)) u_rec (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[k]),
            .wmask   (wmask),
            .wbits   (wbits),
            .core_id (core_id[32*k +: 32]),
            .rec_q   (recs[k]),
            .fire_q  (fire[k])
        );
    end

    // launch payload from the record whose strobe is up
    always_comb begin
        rel_base   = '0;
        rel_offset = '0;
        rel_arg    = '0;
        rel_win    = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            if (fire[k]) begin
                ea          = recs[k][EA_HI -: 64];
                rel_base   |= ea & ~WIN_MASK;
                rel_offset |= ea & WIN_MASK;
                rel_arg    |= recs[k][ARG_HI -: 64];
                rel_win    |= WIN_SIZE;
            end
        end
        ea = '0;
    end
    assign rel_pulse = fire;

    // read path
    always_comb begin
        rd_d      = rd_q;
        rd_d.rerr = 1'b0;
        sel       = in_range ? recs[idx] : '0;
        if (bus_req && !bus_wr) begin
            rd_d.rdata = '0;
            if (size_ok) begin
                for (int i = 0; i < BUS_BYTES; i++) begin
                    if (i < int'(bus_size)) begin
                        rd_d.rdata = {rd_d.rdata[BUS_W-9:0],
                            sel[8*(REC_BYTES-1-(int'(base_off)+i)) +: 8]};
                    end
                end
            end else begin
                rd_d.rerr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign bus_rerr  = rd_q.rerr;

    // R6: at most one core strobed per cycle
    p_onehot_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));
    // R5: boot core is never released
    p_core0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_pulse[0]);
    // R4: bad read size flags an error next cycle
    p_bad_read_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && !(bus_size == 3'd1 || bus_size == 3'd2
                                 || bus_size == 3'd4))
        |=> (bus_rerr && bus_rdata == '0));
    // R8: window split is consistent while strobed
    p_payload_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> (rel_base[WIN_LOG2-1:0] == '0
                          && rel_offset[63:WIN_LOG2] == '0
                          && rel_win == WIN_SIZE));
    // R8: payload idle without strobe
    p_payload_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|rel_pulse) |-> (rel_base == '0 && rel_offset == '0
                           && rel_arg == '0 && rel_win == '0));
endmodule

// File: tb/spin_release_ctrl_test.sv
module spin_release_ctrl_test;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [2:0]    bus_size = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rerr;
    logic [NC-1:0] core_present;
    logic [32*NC-1:0] core_id;
    logic [NC-1:0] rel_pulse;
    logic [63:0]   rel_base, rel_offset, rel_arg, rel_win;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spin_release_ctrl #(.NUM_CORES(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
        .core_present(core_present), .core_id(core_id),
        .rel_pulse(rel_pulse), .rel_base(rel_base), .rel_offset(rel_offset),
        .rel_arg(rel_arg), .rel_win(rel_win)
    );

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [2:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'd7,   3'd1, 32'h0,        32'h1},
        '{1'b0, 10'd108, 3'd4, 32'h0,        32'h3},
        '{1'b0, 10'd116, 3'd4, 32'h0,        32'h3},
        '{1'b0, 10'd96,  3'd4, 32'h0,        32'h0},
        '{1'b1, 10'd64,  3'd4, 32'h12345678, 32'h0},
        '{1'b0, 10'd64,  3'd2, 32'h0,        32'h1234},
        '{1'b0, 10'd66,  3'd1, 32'h0,        32'h56},
        '{1'b0, 10'd65,  3'd1, 32'h0,        32'h34},
        '{1'b0, 10'd67,  3'd2, 32'h0,        32'h5678},
        '{1'b1, 10'd82,  3'd1, 32'hAB,       32'h0},
        '{1'b0, 10'd80,  3'd4, 32'h0,        32'h0000AB00},
        '{1'b1, 10'd89,  3'd2, 32'hBEEF,     32'h0},
        '{1'b0, 10'd88,  3'd4, 32'h0,        32'hBEEF0000},
        '{1'b1, 10'd80,  3'd3, 32'hFFFFFFFF, 32'h0},
        '{1'b0, 10'd80,  3'd4, 32'h0,        32'h0000AB00},
        '{1'b1, 10'd0,   3'd4, 32'hFFFFFFFF, 32'h0},
        '{1'b0, 10'd0,   3'd4, 32'h0,        32'h0},
        '{1'b1, 10'd172, 3'd4, 32'h55,       32'h0},
        '{1'b0, 10'd172, 3'd4, 32'h0,        32'h5},
        '{1'b0, 10'd71,  3'd1, 32'h0,        32'h1},
        '{1'b0, 10'd84,  3'd4, 32'h0,        32'h2}
    };

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic do_op(input logic wr, input logic [9:0] a,
                         input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz;
        bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_rel(input string req, input logic [NC-1:0] p,
                           input logic [63:0] b, input logic [63:0] o,
                           input logic [63:0] g, input logic [63:0] w);
        chk({req, " pulse"},  64'(rel_pulse), 64'(p));
        chk({req, " base"},   rel_base, b);
        chk({req, " offset"}, rel_offset, o);
        chk({req, " arg"},    rel_arg, g);
        chk({req, " win"},    rel_win, w);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements act=timeout exp=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        core_present = '1;
        core_present[5] = 1'b0;
        for (int k = 0; k < NC; k++) core_id[32*k +: 32] = 32'h100 + k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        chk("R1 reset pulse", 64'(rel_pulse), 64'h0);
        chk("R1 reset rerr",  64'(bus_rerr), 64'h0);

        // table: R1 R2 R3 R5 layout, lanes, drops
        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].wr, VECS[v].addr, VECS[v].size, VECS[v].data);
            if (VECS[v].wr)
                chk($sformatf("R3 R5 R6 table row %0d no pulse", v),
                    64'(rel_pulse), 64'h0);
            else
                chk($sformatf("R1 R2 R3 R4 R5 table row %0d rdata", v),
                    64'(bus_rdata), 64'(VECS[v].exp));
        end

        // R10 R6 R8: low-word write releases core 2, merged with high word
        do_op(1'b1, 10'd68, 3'd4, 32'h0ABCDEF0);
        chk_rel("R10 R6 R8 release core2", 32'h4, 64'h12345678_08000000,
                64'h0000_0000_02BCDEF0, 64'h2, 64'h4000000);
        @(negedge clk);
        chk("R6 one-cycle pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b0, 10'd84, 3'd4, 32'h0);
        chk("R9 ID word loaded", 64'(bus_rdata), 64'h102);

        // R7: no re-release while bit 0 stays clear
        do_op(1'b1, 10'd64, 3'd4, 32'h0);
        chk("R7 no duplicate pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b1, 10'd71, 3'd1, 32'h01);
        chk("R7 rearm write no pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b1, 10'd71, 3'd1, 32'h00);
        chk_rel("R7 R8 second release core2", 32'h4, 64'h08000000,
                64'h02BCDE00, 64'h2, 64'h4000000);

        // R5: boot core and absent core cannot be released
        do_op(1'b1, 10'd4, 3'd4, 32'h0);
        chk("R5 core0 no pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b0, 10'd4, 3'd4, 32'h0);
        chk("R5 core0 unchanged", 64'(bus_rdata), 64'h1);
        do_op(1'b1, 10'd164, 3'd4, 32'h0);
        chk("R5 absent core no pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b0, 10'd164, 3'd4, 32'h0);
        chk("R5 absent core unchanged", 64'(bus_rdata), 64'h1);

        // R4: bad read sizes
        do_op(1'b0, 10'd100, 3'd3, 32'h0);
        chk("R4 size3 rerr", 64'(bus_rerr), 64'h1);
        chk("R4 size3 rdata", 64'(bus_rdata), 64'h0);
        @(negedge clk);
        chk("R4 rerr one cycle", 64'(bus_rerr), 64'h0);
        do_op(1'b0, 10'd100, 3'd0, 32'h0);
        chk("R4 size0 rerr", 64'(bus_rerr), 64'h1);

        // R8 R6: core 7 with new argument, byte write clears bit 0
        do_op(1'b1, 10'd236, 3'd4, 32'hCAFEF00D);
        chk("R6 arg write no pulse", 64'(rel_pulse), 64'h0);
        do_op(1'b1, 10'd231, 3'd1, 32'h0);
        chk_rel("R8 R6 release core7", 32'h80, 64'h0, 64'h0,
                64'h00000000_CAFEF00D, 64'h4000000);
        do_op(1'b0, 10'd244, 3'd4, 32'h0);
        chk("R9 core7 ID word", 64'(bus_rdata), 64'h107);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule